// File: doc/BRIEF.md
# Mode-Gated Control Register Guard

This block holds the control and configuration fields of a serial communication controller. Each field carries its own write permission, which depends on the controller's operating mode, on the state reported by the protocol engine, and on whether the related message buffer is currently enabled. A bus write is split into byte lanes. Each field in an enabled lane is then judged on its own. A field whose permission is false keeps its old value, and no error of any kind is signalled.

Some fields have reset triggers beyond the system reset. A protocol-command write carrying the start code clears the error counter. When a buffer's disable is granted, that buffer's cycle filter is cleared.

The block also contains a small handshake for each message buffer. A disable request that hits an enabled buffer is granted one clock later, and the grant clears the buffer's status bit. An enable request sets the status bit, but only while the module runs in normal mode. Some fields have no defined reset value, and the system reset never loads them.

Top module: `ccreg_guard`

## Requirements
- R1: After system reset, reads return: mode register 0x0000 (run bit 0, divider 0), command 0x0000, timing low byte (cycle length) 0xFF, error counter 0, every buffer cycle filter (config bits 15:8) 0, buffer control 0, and `buf_en` reads 0.
- R2: Slot count (timing bits 15:8), scratch (error register bits 15:8) and buffer frame IDs (config bits 7:0) keep their values through a system reset.
- R3: The clock divider (address 0, bits 7:4) is written only while the run bit (address 0, bit 0) is 0. The run bit itself is always writable.
- R4: The command field (address 1, bits 3:0) is written only while the run bit is 1.
- R5: The cycle length (address 2, bits 7:0) is written only while `proto_state` equals CFG_CODE (default 3'b010).
- R6: The slot count (address 2, bits 15:8) is written when `proto_state` equals CFG_CODE or the run bit is 0.
- R7: The config register of buffer b (address 4+b) is written only while that buffer's status bit is 0.
- R8: Byte enable bit i gates bits 8i+7:8i. Each field in one write is judged against the state held before that write.
- R9: When a landed command write carries code 4'b0101, the error counter (address 3, bits 7:0) clears. Other codes leave it unchanged.
- R10: A write to the buffer control register (address 4+NBUF) with bit 8+b set sets status b at that clock edge, but only while the run bit is 1.
- R11: A write to the control register with bit b set while status b is 1 clears status b and buffer b's cycle filter one clock after the write edge. If status b is 0, the request has no effect.
- R12: `rdata` shows the field values at the address sampled on the previous clock edge, whatever the permission state. The control register reads status bits in bits NBUF-1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Register address (write and read) |
| wdata | input | DW | Write data |
| be | input | DW/8 | Byte-lane enables |
| proto_state | input | 3 | State from the protocol engine |
| rdata | output | DW | Registered read data |
| mod_en | output | 1 | Run bit (normal mode) |
| buf_en | output | NBUF | Status bits of the message buffers |

## Verification
The pending cycle of the disable handshake is the hardest window to see. The buffer is still marked enabled there, but its grant is already committed. The stimulus issues a disable request and samples `buf_en` at the falling edge right after the write edge, where the bit must still be 1, and again one clock later, where it must be 0. The frame ID then has to survive while the filter is cleared. A further case is a single write that flips the run bit and touches the divider in the same byte. It shows that each permission is taken from the state held before the write.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  // permission condition bits; a field mask ORs the conditions it accepts
  localparam logic [4:0] PERM_ANY  = 5'b00001;
  localparam logic [4:0] PERM_DIS  = 5'b00010;
  localparam logic [4:0] PERM_NORM = 5'b00100;
  localparam logic [4:0] PERM_CFG  = 5'b01000;
  localparam logic [4:0] PERM_MBD  = 5'b10000;

  localparam int A_MODE   = 0;
  localparam int A_CMD    = 1;
  localparam int A_TIME   = 2;
  localparam int A_ERR    = 3;
  localparam int BUF_BASE = 4;

  function automatic logic perm_ok(input logic [4:0] mask, input logic [4:0] cond);
    return |(mask & cond);
  endfunction
endpackage

// File: rtl/ccg_field.sv
module ccg_field #(
  parameter int         W       = 8,
  parameter logic [4:0] PERM    = 5'b00001,
  parameter bit         HAS_RST = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  input  logic [4:0]   cond,
  input  logic         clr,
  output logic [W-1:0] q
);
  import ccg_pkg::*;
  logic ok;
  assign ok = we && perm_ok(PERM, cond);

  generate
    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk) begin
        if (rst || clr) q <= RST_VAL;
        else if (ok)    q <= d;
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        if (clr)     q <= RST_VAL;
        else if (ok) q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/ccg_buf_ctl.sv
module ccg_buf_ctl (
  input  logic clk,
  input  logic rst,
  input  logic en_trig,
  input  logic dis_trig,
  input  logic run,
  output logic status,
  output logic grant
);
  logic pend;
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
      pend   <= 1'b0;
    end else begin
      pend <= dis_trig && status && !pend;
      if (pend)                 status <= 1'b0;
      else if (en_trig && run)  status <= 1'b1;
    end
  end
  assign grant = pend;
endmodule

// File: rtl/ccreg_guard.sv
module ccreg_guard #(
  parameter int         NBUF     = 4,
  parameter int         AW       = 4,
  parameter int         DW       = 16,
  parameter logic [2:0] CFG_CODE = 3'd2,
  parameter logic [3:0] RUN_CODE = 4'b0101
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] be,
  input  logic [2:0]      proto_state,
  output logic [DW-1:0]   rdata,
  output logic            mod_en,
  output logic [NBUF-1:0] buf_en
);
  import ccg_pkg::*;
  localparam int CTL_ADDR = BUF_BASE + NBUF;

  logic            mod_en_q;
  logic [3:0]      clk_div_q, cmd_q;
  logic [7:0]      clen_q, slot_q, err_q, scr_q;
  logic [NBUF-1:0][7:0] fid_q, filt_q;
  logic [NBUF-1:0] buf_st, grant;

  logic sel_mode, sel_cmd, sel_time, sel_err, sel_ctl, run_hit;
  logic [4:0] cond_g;

  assign sel_mode = wr_en && (addr == AW'(A_MODE));
  assign sel_cmd  = wr_en && (addr == AW'(A_CMD));
  assign sel_time = wr_en && (addr == AW'(A_TIME));
  assign sel_err  = wr_en && (addr == AW'(A_ERR));
  assign sel_ctl  = wr_en && (addr == AW'(CTL_ADDR));
  assign cond_g   = {1'b0, (proto_state == CFG_CODE), mod_en_q, !mod_en_q, 1'b1};
  assign run_hit  = sel_cmd && be[0] && mod_en_q && (wdata[3:0] == RUN_CODE);

  ccg_field #(.W(1), .PERM(PERM_ANY), .HAS_RST(1'b1), .RST_VAL(1'b0)) u_run (
    .clk(clk), .rst(rst), .we(sel_mode && be[0]), .d(wdata[0]), .cond(cond_g), .clr(1'b0), .q(mod_en_q));
  ccg_field #(.W(4), .PERM(PERM_DIS), .HAS_RST(1'b1), .RST_VAL(4'h0)) u_div (
    .clk(clk), .rst(rst), .we(sel_mode && be[0]), .d(wdata[7:4]), .cond(cond_g), .clr(1'b0), .q(clk_div_q));
  ccg_field #(.W(4), .PERM(PERM_NORM), .HAS_RST(1'b1), .RST_VAL(4'h0)) u_cmd (
    .clk(clk), .rst(rst), .we(sel_cmd && be[0]), .d(wdata[3:0]), .cond(cond_g), .clr(1'b0), .q(cmd_q));
  ccg_field #(.W(8), .PERM(PERM_CFG), .HAS_RST(1'b1), .RST_VAL(8'hFF)) u_clen (
    .clk(clk), .rst(rst), .we(sel_time && be[0]), .d(wdata[7:0]), .cond(cond_g), .clr(1'b0), .q(clen_q));
  ccg_field #(.W(8), .PERM(PERM_CFG | PERM_DIS), .HAS_RST(1'b0), .RST_VAL(8'h00)) u_slot (
    .clk(clk), .rst(rst), .we(sel_time && be[1]), .d(wdata[15:8]), .cond(cond_g), .clr(1'b0), .q(slot_q));
  ccg_field #(.W(8), .PERM(PERM_ANY), .HAS_RST(1'b1), .RST_VAL(8'h00)) u_err (
    .clk(clk), .rst(rst), .we(sel_err && be[0]), .d(wdata[7:0]), .cond(cond_g), .clr(run_hit), .q(err_q));
  ccg_field #(.W(8), .PERM(PERM_ANY), .HAS_RST(1'b0), .RST_VAL(8'h00)) u_scr (
    .clk(clk), .rst(rst), .we(sel_err && be[1]), .d(wdata[15:8]), .cond(cond_g), .clr(1'b0), .q(scr_q));

  generate
    for (genvar b = 0; b < NBUF; b++) begin : g_buf
      logic       sel_b;
      logic [4:0] cond_b;
      assign sel_b  = wr_en && (addr == AW'(BUF_BASE + b));
      assign cond_b = {!buf_st[b], cond_g[3:0]};

      ccg_buf_ctl u_hs (
        .clk(clk), .rst(rst),
        .en_trig(sel_ctl && be[1] && wdata[8+b]),
        .dis_trig(sel_ctl && be[0] && wdata[b]),
        .run(mod_en_q), .status(buf_st[b]), .grant(grant[b]));
      ccg_field #(.W(8), .PERM(PERM_MBD), .HAS_RST(1'b0), .RST_VAL(8'h00)) u_fid (
        .clk(clk), .rst(rst), .we(sel_b && be[0]), .d(wdata[7:0]), .cond(cond_b), .clr(1'b0), .q(fid_q[b]));
      ccg_field #(.W(8), .PERM(PERM_MBD), .HAS_RST(1'b1), .RST_VAL(8'h00)) u_filt (
        .clk(clk), .rst(rst), .we(sel_b && be[1]), .d(wdata[15:8]), .cond(cond_b), .clr(grant[b]), .q(filt_q[b]));
    end
  endgenerate

  logic [DW-1:0] rd_n;
  always_comb begin
    rd_n = '0;
    if (addr == AW'(A_MODE)) rd_n = DW'({clk_div_q, 3'b000, mod_en_q});
    if (addr == AW'(A_CMD))  rd_n = DW'(cmd_q);
    if (addr == AW'(A_TIME)) rd_n = DW'({slot_q, clen_q});
    if (addr == AW'(A_ERR))  rd_n = DW'({scr_q, err_q});
    if (addr == AW'(CTL_ADDR)) rd_n = DW'(buf_st);
    for (int b = 0; b < NBUF; b++)
      if (addr == AW'(BUF_BASE + b)) rd_n = DW'({filt_q[b], fid_q[b]});
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

  assign mod_en = mod_en_q;
  assign buf_en = buf_st;
endmodule

// File: rtl/ccg_chk.sv
module ccg_chk #(
  parameter int         NBUF     = 4,
  parameter int         AW       = 4,
  parameter int         DW       = 16,
  parameter logic [2:0] CFG_CODE = 3'd2,
  parameter logic [3:0] RUN_CODE = 4'b0101
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [DW/8-1:0] be,
  input logic [2:0]      proto_state,
  input logic            mod_en,
  input logic [NBUF-1:0] buf_en,
  input logic [3:0]      clk_div_q,
  input logic [3:0]      cmd_q,
  input logic [7:0]      clen_q,
  input logic [7:0]      err_q,
  input logic [NBUF-1:0][7:0] filt_q
);
  localparam int CTL_ADDR = 4 + NBUF;

  // R3: divider frozen while running
  p_div_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mod_en)) |-> $stable(clk_div_q));
  // R4: command frozen while disabled
  p_cmd_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mod_en)) |-> $stable(cmd_q));
  // R5: cycle length frozen outside CONFIG
  p_clen_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(proto_state) != CFG_CODE)) |-> $stable(clen_q));
  // R9: start code clears error counter
  p_run_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(1) && be[0] && mod_en && wdata[3:0] == RUN_CODE) |=> (err_q == 8'h00));

  generate
    for (genvar b = 0; b < NBUF; b++) begin : g_b
      // R10: a buffer only becomes enabled in normal mode
      p_en_norm_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(buf_en[b])) |-> $past(mod_en));
      // R11: grant one clock after the request edge
      p_dis_lat_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(CTL_ADDR) && be[0] && wdata[b] && buf_en[b]) |=> (buf_en[b] ##1 !buf_en[b]));
      // R11: filter cleared whenever the buffer drops to disabled
      p_filt_clr_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(buf_en[b]) |-> (filt_q[b] == 8'h00));
    end
  endgenerate
endmodule

bind ccreg_guard ccg_chk #(.NBUF(NBUF), .AW(AW), .DW(DW), .CFG_CODE(CFG_CODE), .RUN_CODE(RUN_CODE)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .be(be),
  .proto_state(proto_state), .mod_en(mod_en), .buf_en(buf_en),
  .clk_div_q(clk_div_q), .cmd_q(cmd_q), .clen_q(clen_q), .err_q(err_q), .filt_q(filt_q));

// File: tb/ccreg_guard_bench.sv
module ccreg_guard_bench;
  localparam int NB = 4;
  localparam int CTL = 4 + NB;
  localparam logic [2:0] CFG = 3'd2;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0] be = '0;
  logic [2:0] ps = '0;
  logic [15:0] rdata;
  logic mod_en;
  logic [NB-1:0] buf_en;

  always #10 clk = ~clk;

  ccreg_guard u_ccreg_guard (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .be(be), .proto_state(ps), .rdata(rdata), .mod_en(mod_en), .buf_en(buf_en));

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic m_mod; logic [3:0] m_div, m_cmd; logic [7:0] m_clen, m_slot, m_err, m_scr;
  logic [7:0] m_fid [NB]; logic [7:0] m_filt [NB]; logic [NB-1:0] m_st;

  typedef struct { logic [15:0] exp; string tag; logic [3:0] a; } item_t;
  item_t q[$];
  bit pending = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [3:0] a);
    if (a == 0) return {8'h00, m_div, 3'b000, m_mod};
    if (a == 1) return {12'h000, m_cmd};
    if (a == 2) return {m_slot, m_clen};
    if (a == 3) return {m_scr, m_err};
    if (a >= 4 && a < 4 + NB) return {m_filt[a-4], m_fid[a-4]};
    if (a == CTL) return {{(16-NB){1'b0}}, m_st};
    return 16'h0000;
  endfunction

  task automatic model_rst();
    m_mod = 0; m_div = 0; m_cmd = 0; m_clen = 8'hFF; m_err = 0; m_st = '0;
    for (int b = 0; b < NB; b++) m_filt[b] = 8'h00;
  endtask

  // driver: read request pushes the expected item; monitor compares
  task automatic rd(input logic [3:0] a, input string tag);
    item_t it;
    @(negedge clk); addr = a;
    it.exp = exp_rd(a); it.tag = tag; it.a = a;
    q.push_back(it);
    @(posedge clk); #1 pending = 1;
    wait (pending == 0);
  endtask

  always @(negedge clk) begin
    if (pending) begin
      item_t it;
      it = q.pop_front();
      chk($sformatf("%s rd@%0d", it.tag, it.a), rdata, it.exp);
      pending = 0;
    end
  end

  // bus write plus model update; one idle cycle for any disable grant
  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] e);
    logic old; logic cfg; logic [NB-1:0] pend;
    old = m_mod; cfg = (ps == CFG); pend = '0;
    @(negedge clk); wr_en = 1; addr = a; wdata = d; be = e;
    @(negedge clk); wr_en = 0; be = '0;
    if (a == 0 && e[0]) begin m_mod = d[0]; if (!old) m_div = d[7:4]; end
    if (a == 1 && e[0] && old) begin m_cmd = d[3:0]; if (d[3:0] == 4'b0101) m_err = 0; end
    if (a == 2) begin
      if (e[0] && cfg) m_clen = d[7:0];
      if (e[1] && (cfg || !old)) m_slot = d[15:8];
    end
    if (a == 3) begin if (e[0]) m_err = d[7:0]; if (e[1]) m_scr = d[15:8]; end
    if (a >= 4 && a < 4 + NB && !m_st[a-4]) begin
      if (e[0]) m_fid[a-4] = d[7:0];
      if (e[1]) m_filt[a-4] = d[15:8];
    end
    if (a == CTL) for (int b = 0; b < NB; b++) begin
      pend[b] = e[0] && d[b] && m_st[b];
      if (e[1] && d[8+b] && old) m_st[b] = 1'b1;
    end
    @(negedge clk);
    for (int b = 0; b < NB; b++) if (pend[b]) begin m_st[b] = 1'b0; m_filt[b] = 8'h00; end
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a <= CTL; a++) rd(a[3:0], tag);
  endtask

  initial begin
    model_rst();
    repeat (3) @(negedge clk);
    rst = 0;
    rd_all("R1 reset");
    chk("R1 mod_en", {15'h0, mod_en}, 16'h0);
    chk("R1 buf_en", {12'h0, buf_en}, 16'h0);

    // disabled mode, not CONFIG
    ps = 3'd0;
    wr(0, 16'h0050, 2'b01); rd(0, "R3 div in disabled");
    wr(2, 16'hAB12, 2'b11); rd(2, "R5 R6 blocked clen, slot via disabled");
    ps = CFG;
    wr(2, 16'h1234, 2'b11); rd(2, "R5 R6 CONFIG");
    wr(1, 16'h0003, 2'b01); rd(1, "R4 cmd blocked while disabled");
    wr(0, 16'h0091, 2'b01); rd(0, "R8 run and div same write");
    chk("R8 mod_en port", {15'h0, mod_en}, 16'h1);
    wr(0, 16'h0031, 2'b01); rd(0, "R3 div frozen while running");
    wr(2, 16'h5678, 2'b11); rd(2, "R6 slot via CONFIG");
    ps = 3'd5;
    wr(2, 16'h9ABC, 2'b11); rd(2, "R5 R6 both blocked");
    wr(1, 16'h0003, 2'b01); rd(1, "R4 cmd in normal");

    wr(3, 16'h4411, 2'b11);
    wr(3, 16'hCDEF, 2'b01); rd(3, "R8 low lane only");
    wr(3, 16'h77AA, 2'b10); rd(3, "R8 high lane only");
    wr(1, 16'h0005, 2'b00); rd(1, "R8 no lanes");
    wr(1, 16'h0005, 2'b01); rd(3, "R9 start code clears err");
    wr(3, 16'h0022, 2'b01);
    wr(1, 16'h0006, 2'b01); rd(3, "R9 other code keeps err");

    for (int b = 0; b < NB; b++) wr(4 + b, {8'h30 + 8'(b), 8'h40 + 8'(b)}, 2'b11);
    wr(CTL, 16'h0500, 2'b10);
    chk("R10 enable in normal", {12'h0, buf_en}, 16'h0005);
    rd(CTL, "R12 ctl read");
    wr(4, 16'h1111, 2'b11); rd(4, "R7 blocked while enabled");
    rd(5, "R7 other buffer");

    // disable handshake timing, buffer 0
    @(negedge clk); wr_en = 1; addr = CTL; wdata = 16'h0001; be = 2'b01;
    @(negedge clk); wr_en = 0; be = '0;
    chk("R11 pending still enabled", {15'h0, buf_en[0]}, 16'h1);
    @(negedge clk);
    chk("R11 granted", {15'h0, buf_en[0]}, 16'h0);
    m_st[0] = 1'b0; m_filt[0] = 8'h00;
    rd(4, "R11 filter cleared, id kept");
    wr(CTL, 16'h0002, 2'b01);
    chk("R11 no effect when disabled", {12'h0, buf_en}, 16'h0004);
    rd(5, "R11 buffer1 untouched");
    wr(4, 16'h6677, 2'b11); rd(4, "R7 writable after disable");

    wr(0, 16'h0000, 2'b01);
    wr(CTL, 16'h0200, 2'b10);
    chk("R10 enable ignored in disabled", {12'h0, buf_en}, 16'h0004);
    rd(CTL, "R10 ctl read");

    // mid-run system reset
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    model_rst();
    rd_all("R2 R1 after second reset");
    chk("R1 buf_en after reset", {12'h0, buf_en}, 16'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule